// File: doc/BRIEF.md
# Frame Buffer Control Register Bank

This block is the control and interrupt slice of a simple frame buffer controller. It sits behind a byte-wide register bus and decodes a 32-byte window. The lower half of the window belongs to colour-map logic that lives elsewhere, so here it reads as zero and ignores writes. The upper half holds three things:

- a control byte whose top bit arms the end-of-frame interrupt;
- a status byte that reports a sticky pending flag merged with fixed identification bits;
- fourteen plain storage bytes used for cursor and video-control settings.

A one-cycle end-of-frame pulse from the timing logic sets the pending flag when the interrupt is armed. The interrupt output is a level that follows that flag. Software clears the flag by writing any value to the status byte.

Each bus access takes one cycle. Read data is registered: it appears after the clock edge that accepts the read, and it holds until the next read.

Top module: `fbc_regbank`

## Requirements
- R1: After a synchronous active-low reset, `irq` is low, the control byte and all storage bytes read 0x00, the status byte reads 0x61, and `rd_data` is 0x00.
- R2: Offset 0x10 is the control byte. A write stores all 8 bits, a read returns them, and bit 7 is the interrupt enable.
- R3: A read of offset 0x11 returns bit 7 equal to the pending flag and bits 6..0 equal to 0x61: monitor code 0x60 ORed with colour ID 0x01. It therefore reads 0xE1 when the flag is set and 0x61 when it is clear.
- R4: A write of any value to offset 0x11 clears the pending flag and stores no data. Writing 0xFF to a clear flag still reads back 0x61.
- R5: When `vsync_pulse` is high at a clock edge and control bit 7 is set, the pending flag is set at that edge. `irq` is high from that edge onward.
- R6: When `vsync_pulse` is high while control bit 7 is clear, the pending flag and `irq` do not change.
- R7: The pending flag is sticky. Clearing control bit 7 or letting further pulses arrive does not clear it; only a status write does.
- R8: When a status write and an armed end-of-frame pulse fall on the same edge, the pulse wins and the flag stays set.
- R9: Offsets 0x12 through 0x1F are independent byte registers that read back the last value written to each.
- R10: Offsets 0x00 through 0x0F read 0x00, and writes to them change no register.
- R11: `rd_data` takes the addressed value at the edge that accepts a read. It keeps that value through idle cycles and writes until the next read.
- R12: An end-of-frame pulse is judged against the control value held before its edge. A control write on the same edge takes effect only for later pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| vsync_pulse | input | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The hardest situations to reach are the same-edge collisions. One is a status clear landing on the same edge as an armed end-of-frame pulse. The other is a control write that arms or disarms the interrupt on the same edge as a pulse.

The stimulus drives the bus access and the pulse together in a single cycle to make each collision happen. It then reads the status byte and watches `irq` against a behavioural model that is updated on every clock.

// File: rtl/fbc_pkg.sv
// Package: shared constants and types for the frame buffer control register bank.
// Assumes a 32-byte byte-addressed window with the control group in its upper half.
package fbc_pkg;

    localparam int ADDR_W        = 5;
    localparam int OFF_CTRL      = 5'h10;
    localparam int OFF_STAT      = 5'h11;
    localparam int OFF_SCR_FIRST = 5'h12;
    localparam int WINDOW_BYTES  = 1 << ADDR_W;
    localparam int SCR_COUNT     = WINDOW_BYTES - OFF_SCR_FIRST;
    localparam int SCR_IDX_W     = $clog2(SCR_COUNT);
    localparam int IRQ_EN_BIT    = 7;
    localparam int PEND_BIT      = 7;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_SCR  = 2'd3
    } fbc_sel_e;

    typedef struct packed {
        fbc_sel_e             sel;
        logic [SCR_IDX_W-1:0] scr_idx;
    } fbc_dec_t;

endpackage

// File: rtl/fbc_decode.sv
// Module: fbc_decode
// Maps a window offset onto a register group, plus an index into storage.
// Assumes the control, status and storage groups are contiguous and start at OFF_CTRL.
// Everything below OFF_CTRL decodes as unmapped.
module fbc_decode
    import fbc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output fbc_dec_t          dec
);

    logic [ADDR_W-1:0] scr_off;

    // Offset of the access relative to the first storage byte.
    always_comb scr_off = addr - ADDR_W'(OFF_SCR_FIRST);

    // Classify the offset into a register group.
    always_comb begin
        dec.scr_idx = scr_off[SCR_IDX_W-1:0];
        if (addr == ADDR_W'(OFF_CTRL))
            dec.sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFF_STAT))
            dec.sel = SEL_STAT;
        else if (addr >= ADDR_W'(OFF_SCR_FIRST))
            dec.sel = SEL_SCR;
        else
            dec.sel = SEL_NONE;
    end

endmodule

// File: rtl/fbc_irq_ctrl.sv
// Module: fbc_irq_ctrl
// Holds the control byte and the sticky pending-interrupt flag.
// Assumes vsync is a single-cycle pulse synchronous to clk.
// An armed pulse takes priority over a clear on the same edge.
// A pulse is judged against the control value held before that edge.
module fbc_irq_ctrl #(
    parameter int DATA_W  = 8,
    parameter int EN_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              stat_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              vsync,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              pend_q
);

    logic frame_hit;

    // An end-of-frame pulse counts only while the interrupt is armed.
    always_comb frame_hit = vsync && ctrl_q[EN_BIT];

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= wdata;
    end

    // Pending flag: set by an armed pulse, cleared by any status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (frame_hit)
            pend_q <= 1'b1;
        else if (stat_we)
            pend_q <= 1'b0;
    end

endmodule

// File: rtl/fbc_scratch_bank.sv
// Module: fbc_scratch_bank
// A bank of COUNT plain byte registers with one write port and one read mux.
// Assumes idx is only meaningful when it is below COUNT; larger indices read zero.
module fbc_scratch_bank #(
    parameter int DATA_W = 8,
    parameter int COUNT  = 14,
    parameter int IDX_W  = $clog2(COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] bytes_q [COUNT];

    for (genvar g = 0; g < COUNT; g++) begin : g_byte
        // One storage byte, written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bytes_q[g] <= '0;
            else if (we && (idx == IDX_W'(g)))
                bytes_q[g] <= wdata;
        end
    end

    // Select the addressed byte, with a guard for indices past the end.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < COUNT; k++)
            if (idx == IDX_W'(k))
                rdata = bytes_q[k];
    end

endmodule

// File: rtl/fbc_regbank.sv
// Module: fbc_regbank (top)
// Control, status and storage register bank of a frame buffer controller.
// Assumes a single-cycle byte bus, where a read or a write is taken on each valid cycle.
// Read data is registered and held between reads.
// The lower half of the window is served elsewhere, so here it reads zero and ignores writes.
module fbc_regbank
    import fbc_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  ID_BITS = 8'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [4:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              vsync_pulse,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    fbc_dec_t          dec;
    logic              wr_en;
    logic              rd_en;
    logic              ctrl_we;
    logic              stat_we;
    logic              scr_we;
    logic [DATA_W-1:0] ctrl_byte;
    logic              pending;
    logic [DATA_W-1:0] scr_rdata;
    logic [DATA_W-1:0] rd_next;

    fbc_decode i_decode (
        .addr (bus_addr),
        .dec  (dec)
    );

    // Qualify bus direction and steer write strobes by group.
    always_comb begin
        wr_en   = bus_valid && bus_write;
        rd_en   = bus_valid && !bus_write;
        ctrl_we = wr_en && (dec.sel == SEL_CTRL);
        stat_we = wr_en && (dec.sel == SEL_STAT);
        scr_we  = wr_en && (dec.sel == SEL_SCR);
    end

    fbc_irq_ctrl #(
        .DATA_W (DATA_W),
        .EN_BIT (IRQ_EN_BIT)
    ) i_irq_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .stat_we (stat_we),
        .wdata   (bus_wdata),
        .vsync   (vsync_pulse),
        .ctrl_q  (ctrl_byte),
        .pend_q  (pending)
    );

    fbc_scratch_bank #(
        .DATA_W (DATA_W),
        .COUNT  (SCR_COUNT),
        .IDX_W  (SCR_IDX_W)
    ) i_scratch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (scr_we),
        .idx   (dec.scr_idx),
        .wdata (bus_wdata),
        .rdata (scr_rdata)
    );

    // Assemble the value that a read of the current offset returns.
    always_comb begin
        rd_next = '0;
        case (dec.sel)
            SEL_CTRL: rd_next = ctrl_byte;
            SEL_STAT: begin
                rd_next           = DATA_W'(ID_BITS);
                rd_next[PEND_BIT] = rd_next[PEND_BIT] | pending;
            end
            SEL_SCR:  rd_next = scr_rdata;
            default:  rd_next = '0;
        endcase
    end

    // Capture read data on an accepted read and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end

    // The interrupt line is the registered pending flag itself.
    always_comb irq = pending;

endmodule

// File: rtl/fbc_regbank_chk.sv
// Module: fbc_regbank_chk
// Temporal checks on the register bank, attached to the top module by bind.
module fbc_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_valid,
    input logic       bus_write,
    input logic [4:0] bus_addr,
    input logic       vsync,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic       irq_en
);

    logic stat_wr;
    logic armed_hit;

    always_comb stat_wr   = bus_valid && bus_write && (bus_addr == 5'h11);
    always_comb armed_hit = vsync && irq_en;

    a_r5_armed_sets: assert property (@(posedge clk) disable iff (!rst_n)
        armed_hit |=> irq);

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !armed_hit) |=> !irq);

    a_r4_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !armed_hit) |=> !irq);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_wr) |=> irq);

    a_r3_id_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 5'h11)
        |=> (rd_data[6:0] == 7'h61) && (rd_data[7] == $past(irq)));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr < 5'h10) |=> (rd_data == 8'h00));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(rd_data));

endmodule

bind fbc_regbank fbc_regbank_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .vsync     (vsync_pulse),
    .rd_data   (rd_data),
    .irq       (irq),
    .irq_en    (ctrl_byte[7])
);

// File: tb/test_fbc_regbank.sv
`timescale 1ns/1ps
module test_fbc_regbank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       vsync_pulse = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    // Behavioural reference state.
    int m_ctrl = 0;
    int m_pend = 0;
    int m_rd   = 0;
    int m_scr [14];

    fbc_regbank i_fbc_regbank (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .vsync_pulse (vsync_pulse),
        .rd_data     (rd_data),
        .irq         (irq)
    );

    always #4 clk = ~clk;

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    function automatic int model_read(int a);
        if (a == 16) return m_ctrl;
        if (a == 17) return 'h61 | (m_pend << 7);
        if (a >= 18) return m_scr[a - 18];
        return 0;
    endfunction

    // Advance the reference by one clock edge, using the inputs seen at that edge.
    task automatic model_step();
        int hit;
        int a;
        a = int'(bus_addr);
        if (!rst_n) begin
            m_ctrl = 0; m_pend = 0; m_rd = 0;
            foreach (m_scr[i]) m_scr[i] = 0;
        end else begin
            hit = (vsync_pulse && m_ctrl[7]) ? 1 : 0;
            if (bus_valid && !bus_write) m_rd = model_read(a);
            if (hit != 0) m_pend = 1;
            else if (bus_valid && bus_write && a == 17) m_pend = 0;
            if (bus_valid && bus_write) begin
                if (a == 16) m_ctrl = int'(bus_wdata);
                else if (a >= 18) m_scr[a - 18] = int'(bus_wdata);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({cur_req, " irq vs model"}, int'(irq), m_pend);
        check({cur_req, " rd_data vs model"}, int'(rd_data), m_rd);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(int a, int d, bit vs = 1'b0);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = 5'(a); bus_wdata = 8'(d); vsync_pulse = vs;
        tick();
        bus_valid = 1'b0; bus_write = 1'b0; vsync_pulse = 1'b0;
    endtask

    task automatic rd(int a);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 5'(a);
        tick();
        bus_valid = 1'b0;
    endtask

    task automatic pulse();
        vsync_pulse = 1'b1;
        tick();
        vsync_pulse = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        foreach (m_scr[i]) m_scr[i] = 0;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values
        cur_req = "R1";
        check("R1 irq after reset", int'(irq), 0);
        check("R1 rd_data after reset", int'(rd_data), 0);
        rd(16); check("R1 ctrl reset", int'(rd_data), 'h00);
        rd(17); check("R1 status reset", int'(rd_data), 'h61);
        rd(31); check("R1 storage reset", int'(rd_data), 'h00);

        // R2: control byte storage
        cur_req = "R2";
        wr(16, 'h5A); rd(16); check("R2 ctrl readback", int'(rd_data), 'h5A);

        // R6: pulse while disarmed
        cur_req = "R6";
        pulse(); check("R6 irq stays low", int'(irq), 0);
        rd(17); check("R6 status clear", int'(rd_data), 'h61);

        // R5 and R3: armed pulse
        cur_req = "R5";
        wr(16, 'h80); idle(2);
        check("R5 no irq before pulse", int'(irq), 0);
        pulse(); check("R5 irq raised", int'(irq), 1);
        cur_req = "R3";
        rd(17); check("R3 status pending", int'(rd_data), 'hE1);

        // R4: status write clears, stores nothing
        cur_req = "R4";
        wr(17, 'h00); check("R4 irq cleared", int'(irq), 0);
        wr(17, 'hFF); rd(17); check("R4 status not stored", int'(rd_data), 'h61);

        // R7: sticky flag
        cur_req = "R7";
        pulse(); wr(16, 'h00); idle(3);
        check("R7 still pending after disarm", int'(irq), 1);
        pulse(); check("R7 still pending after pulse", int'(irq), 1);
        wr(17, 'h3C); check("R7 cleared by status write", int'(irq), 0);

        // R8: clear and armed pulse on the same edge
        cur_req = "R8";
        wr(16, 'h80); pulse();
        wr(17, 'h00, 1'b1); check("R8 pulse wins", int'(irq), 1);
        rd(17); check("R8 status", int'(rd_data), 'hE1);
        wr(17, 'h00); check("R8 later clear", int'(irq), 0);

        // R12: control write on a pulse edge uses the old value
        cur_req = "R12";
        wr(16, 'h00, 1'b1); check("R12 disarm same edge still sets", int'(irq), 1);
        wr(17, 'h00);
        wr(16, 'h80, 1'b1); check("R12 arm same edge no set", int'(irq), 0);
        pulse(); check("R12 later pulse sets", int'(irq), 1);
        wr(17, 'h00);

        // R9: storage bytes
        cur_req = "R9";
        for (int a = 18; a < 32; a++) wr(a, (a * 17 + 3) & 'hFF);
        for (int a = 31; a >= 18; a--) begin
            rd(a);
            check($sformatf("R9 storage 0x%0h", a), int'(rd_data), (a * 17 + 3) & 'hFF);
        end

        // R10: unmapped lower half
        cur_req = "R10";
        for (int a = 0; a < 16; a++) wr(a, 'hFF);
        for (int a = 0; a < 16; a += 5) begin
            rd(a); check($sformatf("R10 unmapped 0x%0h", a), int'(rd_data), 0);
        end
        rd(16); check("R10 ctrl untouched", int'(rd_data), 'h80);
        rd(18); check("R10 storage untouched", int'(rd_data), (18 * 17 + 3) & 'hFF);
        rd(17); check("R10 status untouched", int'(rd_data), 'h61);

        // R11: read data holds until the next read
        cur_req = "R11";
        rd(20); idle(3);
        check("R11 hold over idle", int'(rd_data), (20 * 17 + 3) & 'hFF);
        wr(21, 'h99);
        check("R11 hold over write", int'(rd_data), (20 * 17 + 3) & 'hFF);
        rd(21); check("R11 new read", int'(rd_data), 'h99);

        // R1: reset in mid-run restores defaults
        cur_req = "R1";
        pulse();
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        check("R1 irq after second reset", int'(irq), 0);
        rd(21); check("R1 storage after second reset", int'(rd_data), 0);

        finish_run();
    end

endmodule